// File: doc/BRIEF.md
# Receive Checksum Policy Checker

This block watches a received frame one byte per cycle, starting at the first byte of the Ethernet destination address. It decodes the EtherType and the IPv4 header, including the more-fragments flag, the fragment offset and the protocol number. It then sums the layer-4 bytes in ones'-complement arithmetic. For UDP and UDP-Lite the sum also covers the pseudo-header. Once the frame has ended, a short policy stage combines that sum with four configuration inputs and issues a single pass/drop decision for the frame.

The configuration inputs are:
- skip the check for fragmented UDP traffic;
- accept UDP datagrams that carry no checksum (a zero checksum field);
- verify UDP-Lite datagrams;
- verify ICMP messages.

A frame that the block does not recognise passes. That covers frames that are not IPv4, frames with another transport protocol, and frames too short to hold a transport header. The upstream receive path uses the verdict strobe to keep or discard the frame it has stored elsewhere.

Top module: `rx_csum_policy`

## Requirements
- R1: For every beat with `in_valid` and `in_last` high, `verdict_valid` is high for exactly one cycle, two clock edges later. After reset, `verdict_valid` and `verdict_pass` are low.
- R2: These frames always pass:
  - the EtherType (frame bytes 12 and 13) is not 0x0800;
  - the IPv4 version nibble (high nibble of byte 14) is not 4;
  - the header length nibble is below 5;
  - the protocol byte (byte 23) is not 1, 17 or 136.
- R3: A non-fragmented ICMP frame (protocol 1) passes only if its layer-4 sum folds to 0xFFFF, provided `cfg_icmp_chk` is high. With `cfg_icmp_chk` low, every ICMP frame passes.
- R4: A fragmented ICMP frame passes without a check. A frame is fragmented when the more-fragments flag is set or the 13-bit fragment offset is nonzero. The flag is bit 5 of IPv4 header byte 6. The offset is bits 4..0 of that byte followed by byte 7.
- R5: A UDP frame (protocol 17) with a nonzero checksum field passes only if a ones'-complement sum folds to 0xFFFF. The sum covers the layer-4 bytes, both IPv4 addresses, the protocol number and the UDP length field (layer-4 bytes 4 and 5).
- R6: A UDP frame that is not skipped by R7 and whose checksum field (layer-4 bytes 6 and 7) is zero passes only when `cfg_zero_pass` is high.
- R7: With `cfg_frag_pass` high, a fragmented UDP or UDP-Lite frame passes without a check. With it low, fragmentation does not change the result.
- R8: With `cfg_lite_en` low, a UDP-Lite frame (protocol 136) passes. With it high, the frame passes only if its sum, including the pseudo-header, folds to 0xFFFF.
- R9: For UDP-Lite, the coverage field (layer-4 bytes 4 and 5) sets both of these:
  - how many leading layer-4 bytes are summed, where zero means all of them;
  - the length word used in the pseudo-header.
- R10: Bytes at or beyond the IPv4 total length (trailing Ethernet padding) are not summed. An odd final byte is summed as the high half of a word whose low half is zero.
- R11: A recognised ICMP, UDP or UDP-Lite frame passes if it ends before its first eight layer-4 bytes have arrived.
- R12: The configuration inputs are sampled on the final beat of the frame. Changes after that beat do not affect that frame's verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A frame byte is present this cycle |
| in_data | input | 8 | Frame byte, in wire order |
| in_last | input | 1 | This byte is the final one of the frame |
| cfg_frag_pass | input | 1 | Skip checks for fragmented UDP and UDP-Lite |
| cfg_zero_pass | input | 1 | Accept UDP with a zero checksum field |
| cfg_lite_en | input | 1 | Verify UDP-Lite checksums |
| cfg_icmp_chk | input | 1 | Verify non-fragmented ICMP checksums |
| verdict_valid | output | 1 | One-cycle strobe carrying the frame's verdict |
| verdict_pass | output | 1 | 1 = keep the frame, 0 = drop it; holds until the next strobe |

## Verification
A wrong byte counter or a wrong header length shifts which bytes count as layer 4. That moves the pseudo-header and field captures as well, so an otherwise valid frame is dropped at its verdict strobe, two edges after its last byte. A bad coverage or total-length bound is exposed only by frames whose checksum differs inside versus outside that bound: partial UDP-Lite coverage, or trailing padding. Policy-stage faults show as the wrong value on the very first strobe of a frame that has the matching fragment or zero-checksum pattern. No other frame reveals them.

// File: rtl/rxc_pkg.sv
package rxc_pkg;

  localparam int ETH_HDR_LEN = 14;
  localparam int OFF_ETYPE   = 12;
  localparam int OFF_VERIHL  = 14;
  localparam int OFF_TOTLEN  = 16;
  localparam int OFF_FRAG    = 20;
  localparam int OFF_PROTO   = 23;
  localparam int OFF_ADDR_LO = 26;
  localparam int OFF_ADDR_HI = 33;
  localparam int L4_HDR_LEN  = 8;

  localparam logic [15:0] ETYPE_IPV4 = 16'h0800;
  localparam logic [7:0]  PROTO_ICMP = 8'd1;
  localparam logic [7:0]  PROTO_UDP  = 8'd17;
  localparam logic [7:0]  PROTO_LITE = 8'd136;

  typedef struct packed {
    logic [15:0] etype;
    logic [3:0]  ver;
    logic [3:0]  ihl;
    logic [15:0] tot_len;
    logic        mf;
    logic [12:0] frag_off;
    logic [7:0]  proto;
    logic [15:0] f_len;
    logic [15:0] f_csum;
    logic        l4_seen;
  } rxc_hdr_t;

  typedef struct packed {
    logic frag_pass;
    logic zero_pass;
    logic lite_en;
    logic icmp_chk;
  } rxc_cfg_t;

endpackage

// File: rtl/rxc_hdr_parse.sv
module rxc_hdr_parse
  import rxc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             first_beat,
  output logic             hi_byte,
  output logic             addr_beat,
  output logic             l4_beat,
  output rxc_hdr_t         hdr
);

  localparam logic [CNT_W-1:0] IDX_MAX = '1;
  localparam logic [CNT_W-1:0] ETH_C   = CNT_W'(ETH_HDR_LEN);

  logic [CNT_W-1:0] idx_q;
  rxc_hdr_t         h_q, h_d;
  logic [CNT_W-1:0] hlen_bytes, l4_start, ip_rel, l4_rel, l4_len_ip, cov_lim;
  logic             in_l4_area, udpish;

  always_comb begin
    hlen_bytes = CNT_W'({h_q.ihl, 2'b00});
    l4_start   = ETH_C + hlen_bytes;
    ip_rel     = idx_q - ETH_C;
    l4_rel     = idx_q - l4_start;
    l4_len_ip  = CNT_W'(h_q.tot_len) - hlen_bytes;
    udpish     = (h_q.proto == PROTO_UDP) || (h_q.proto == PROTO_LITE);
    cov_lim    = ((h_q.proto == PROTO_LITE) && (h_q.f_len != 16'd0)) ?
                 CNT_W'(h_q.f_len) : l4_len_ip;
    in_l4_area = (idx_q >= l4_start) && (idx_q >= ETH_C) &&
                 (ip_rel < CNT_W'(h_q.tot_len));
  end

  assign first_beat = in_valid && (idx_q == '0);
  assign hi_byte    = ~idx_q[0];
  assign addr_beat  = in_valid && udpish &&
                      (idx_q >= CNT_W'(OFF_ADDR_LO)) && (idx_q <= CNT_W'(OFF_ADDR_HI));
  assign l4_beat    = in_valid && in_l4_area &&
                      ((l4_rel < CNT_W'(L4_HDR_LEN)) || (l4_rel < cov_lim));
  assign hdr        = h_q;

  always_comb begin
    h_d = h_q;
    if (in_valid) begin
      if (idx_q == '0) h_d = '0;
      if (idx_q == CNT_W'(OFF_ETYPE))      h_d.etype[15:8] = in_data;
      if (idx_q == CNT_W'(OFF_ETYPE + 1))  h_d.etype[7:0]  = in_data;
      if (idx_q == CNT_W'(OFF_VERIHL)) begin
        h_d.ver = in_data[7:4];
        h_d.ihl = in_data[3:0];
      end
      if (idx_q == CNT_W'(OFF_TOTLEN))     h_d.tot_len[15:8] = in_data;
      if (idx_q == CNT_W'(OFF_TOTLEN + 1)) h_d.tot_len[7:0]  = in_data;
      if (idx_q == CNT_W'(OFF_FRAG)) begin
        h_d.mf             = in_data[5];
        h_d.frag_off[12:8] = in_data[4:0];
      end
      if (idx_q == CNT_W'(OFF_FRAG + 1))   h_d.frag_off[7:0] = in_data;
      if (idx_q == CNT_W'(OFF_PROTO))      h_d.proto = in_data;
      if (in_l4_area) begin
        if (l4_rel == CNT_W'(4)) h_d.f_len[15:8]  = in_data;
        if (l4_rel == CNT_W'(5)) h_d.f_len[7:0]   = in_data;
        if (l4_rel == CNT_W'(6)) h_d.f_csum[15:8] = in_data;
        if (l4_rel == CNT_W'(7)) begin
          h_d.f_csum[7:0] = in_data;
          h_d.l4_seen     = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      h_q   <= '0;
    end else begin
      h_q <= h_d;
      if (in_valid) begin
        if (in_last)               idx_q <= '0;
        else if (idx_q != IDX_MAX) idx_q <= idx_q + 1'b1;
      end
    end
  end

  // R1: the byte counter restarts after every final beat
  a_r1_idx_restart: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_last) |=> (idx_q == '0));

  // R11: the header-complete flag never survives into a new frame's first byte
  a_r11_seen_cleared: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (idx_q == '0)) |=> !h_q.l4_seen);

endmodule

// File: rtl/rxc_sum_accum.sv
module rxc_sum_accum #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       in_data,
  input  logic             first_beat,
  input  logic             hi_byte,
  input  logic             add_en,
  output logic [ACC_W-1:0] acc
);

  logic [ACC_W-1:0] acc_q, term;

  assign term = hi_byte ? ACC_W'({in_data, 8'h00}) : ACC_W'(in_data);
  assign acc  = acc_q;

  always_ff @(posedge clk) begin
    if (rst)             acc_q <= '0;
    else if (first_beat) acc_q <= '0;
    else if (add_en)     acc_q <= acc_q + term;
  end

  // R10: a beat outside every summed region leaves the sum untouched
  a_r10_hold_outside: assert property (@(posedge clk) disable iff (rst)
    (!first_beat && !add_en) |=> $stable(acc_q));

endmodule

// File: rtl/rxc_verdict.sv
module rxc_verdict
  import rxc_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             end_beat,
  input  rxc_cfg_t         cfg,
  input  rxc_hdr_t         hdr,
  input  logic [ACC_W-1:0] acc,
  output logic             verdict_valid,
  output logic             verdict_pass
);

  logic             end_q, valid_q, pass_q, pass_d;
  rxc_cfg_t         cfg_q;
  logic             is_ip, is_icmp, is_udp, is_lite, frag, sum_ok;
  logic [ACC_W-1:0] total;
  logic [16:0]      fold1;
  logic [15:0]      fold2;

  always_comb begin
    is_ip   = (hdr.etype == ETYPE_IPV4) && (hdr.ver == 4'd4) && (hdr.ihl >= 4'd5);
    is_icmp = hdr.proto == PROTO_ICMP;
    is_udp  = hdr.proto == PROTO_UDP;
    is_lite = hdr.proto == PROTO_LITE;
    frag    = hdr.mf || (hdr.frag_off != 13'd0);
    total   = acc;
    if (is_udp || is_lite) total = acc + ACC_W'(hdr.f_len) + ACC_W'(hdr.proto);
    fold1   = {1'b0, total[15:0]} + 17'(total >> 16);
    fold2   = fold1[15:0] + 16'(fold1[16]);
    sum_ok  = fold2 == 16'hFFFF;

    pass_d = 1'b1;
    if (is_ip && (is_icmp || is_udp || is_lite) && hdr.l4_seen) begin
      if (is_icmp)                         pass_d = !cfg_q.icmp_chk || frag || sum_ok;
      else if (is_lite && !cfg_q.lite_en)  pass_d = 1'b1;
      else if (frag && cfg_q.frag_pass)    pass_d = 1'b1;
      else if (is_udp && (hdr.f_csum == 16'd0)) pass_d = cfg_q.zero_pass;
      else                                 pass_d = sum_ok;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      end_q   <= 1'b0;
      cfg_q   <= '0;
      valid_q <= 1'b0;
      pass_q  <= 1'b0;
    end else begin
      end_q   <= end_beat;
      if (end_beat) cfg_q <= cfg;
      valid_q <= end_q;
      if (end_q) pass_q <= pass_d;
    end
  end

  assign verdict_valid = valid_q;
  assign verdict_pass  = pass_q;

  // R2: unrecognised frames are kept
  a_r2_other_pass: assert property (@(posedge clk) disable iff (rst)
    (end_q && !(is_ip && (is_icmp || is_udp || is_lite))) |=> verdict_pass);

  // R4: fragmented ICMP frames are never dropped
  a_r4_icmp_frag: assert property (@(posedge clk) disable iff (rst)
    (end_q && is_ip && is_icmp && frag) |=> verdict_pass);

  // R6: zero-checksum UDP follows the zero-pass setting captured at the final beat
  a_r6_zero_rule: assert property (@(posedge clk) disable iff (rst)
    (end_q && is_ip && is_udp && hdr.l4_seen && !frag && (hdr.f_csum == 16'd0))
    |=> (verdict_pass == $past(cfg_q.zero_pass)));

  // R8: UDP-Lite with checking off is kept
  a_r8_lite_off: assert property (@(posedge clk) disable iff (rst)
    (end_q && is_ip && is_lite && !cfg_q.lite_en) |=> verdict_pass);

  // R11: truncated transport headers are kept
  a_r11_trunc_pass: assert property (@(posedge clk) disable iff (rst)
    (end_q && !hdr.l4_seen) |=> verdict_pass);

endmodule

// File: rtl/rx_csum_policy.sv
module rx_csum_policy
  import rxc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int ACC_W = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_last,
  input  logic       cfg_frag_pass,
  input  logic       cfg_zero_pass,
  input  logic       cfg_lite_en,
  input  logic       cfg_icmp_chk,
  output logic       verdict_valid,
  output logic       verdict_pass
);

  logic             first_beat, hi_byte, addr_beat, l4_beat;
  rxc_hdr_t         hdr;
  rxc_cfg_t         cfg;
  logic [ACC_W-1:0] acc;

  assign cfg = '{frag_pass: cfg_frag_pass, zero_pass: cfg_zero_pass,
                 lite_en: cfg_lite_en, icmp_chk: cfg_icmp_chk};

  rxc_hdr_parse #(.CNT_W(CNT_W)) u_parse (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .first_beat(first_beat), .hi_byte(hi_byte), .addr_beat(addr_beat),
    .l4_beat(l4_beat), .hdr(hdr)
  );

  rxc_sum_accum #(.ACC_W(ACC_W)) u_sum (
    .clk(clk), .rst(rst), .in_data(in_data), .first_beat(first_beat),
    .hi_byte(hi_byte), .add_en(addr_beat || l4_beat), .acc(acc)
  );

  rxc_verdict #(.ACC_W(ACC_W)) u_verdict (
    .clk(clk), .rst(rst), .end_beat(in_valid && in_last), .cfg(cfg),
    .hdr(hdr), .acc(acc), .verdict_valid(verdict_valid), .verdict_pass(verdict_pass)
  );

  // R1: one strobe, two edges after the final beat
  a_r1_latency: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_last) |=> ##1 verdict_valid);

endmodule

// File: tb/tb_rx_csum_policy.sv
module tb_rx_csum_policy;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic cfg_frag_pass = 1'b0, cfg_zero_pass = 1'b0, cfg_lite_en = 1'b0, cfg_icmp_chk = 1'b0;
  logic verdict_valid, verdict_pass;

  always #10 clk = ~clk;

  rx_csum_policy dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .cfg_frag_pass(cfg_frag_pass), .cfg_zero_pass(cfg_zero_pass),
    .cfg_lite_en(cfg_lite_en), .cfg_icmp_chk(cfg_icmp_chk),
    .verdict_valid(verdict_valid), .verdict_pass(verdict_pass)
  );

  // kind: 0 ICMP, 1 UDP, 2 UDP-Lite, 3 TCP. frag: 0 none, 1 MF, 2 offset.
  // cor: 0 none, 1 inside coverage, 2 beyond a 12-byte coverage. cfg = {F,Z,L,I}
  typedef struct packed {
    logic [1:0] kind;
    logic [1:0] frag;
    logic [1:0] cor;
    logic       zero;
    logic       cov;
    logic       odd;
    logic       pad;
    logic [3:0] cfg;
    logic       exp;
  } vec_t;

  localparam int NVEC = 24;
  localparam logic [14:0] TBL [0:NVEC-1] = '{
    {2'd0,2'd0,2'd0,1'b0,1'b0,1'b0,1'b0,4'b0001,1'b1},
    {2'd0,2'd0,2'd1,1'b0,1'b0,1'b0,1'b0,4'b0001,1'b0},
    {2'd0,2'd0,2'd1,1'b0,1'b0,1'b0,1'b0,4'b1110,1'b1},
    {2'd0,2'd1,2'd1,1'b0,1'b0,1'b0,1'b0,4'b0001,1'b1},
    {2'd0,2'd2,2'd1,1'b0,1'b0,1'b1,1'b0,4'b0001,1'b1},
    {2'd1,2'd0,2'd0,1'b0,1'b0,1'b0,1'b0,4'b0000,1'b1},
    {2'd1,2'd0,2'd1,1'b0,1'b0,1'b0,1'b0,4'b0000,1'b0},
    {2'd1,2'd0,2'd0,1'b0,1'b0,1'b1,1'b0,4'b0000,1'b1},
    {2'd1,2'd0,2'd1,1'b0,1'b0,1'b1,1'b0,4'b0000,1'b0},
    {2'd1,2'd0,2'd0,1'b0,1'b0,1'b0,1'b1,4'b0000,1'b1},
    {2'd1,2'd0,2'd0,1'b1,1'b0,1'b0,1'b0,4'b0100,1'b1},
    {2'd1,2'd0,2'd0,1'b1,1'b0,1'b0,1'b0,4'b0000,1'b0},
    {2'd1,2'd1,2'd1,1'b0,1'b0,1'b0,1'b0,4'b1000,1'b1},
    {2'd1,2'd2,2'd1,1'b0,1'b0,1'b0,1'b0,4'b1000,1'b1},
    {2'd1,2'd1,2'd1,1'b0,1'b0,1'b0,1'b0,4'b0000,1'b0},
    {2'd1,2'd1,2'd0,1'b0,1'b0,1'b0,1'b0,4'b0000,1'b1},
    {2'd2,2'd0,2'd0,1'b0,1'b0,1'b0,1'b0,4'b0010,1'b1},
    {2'd2,2'd0,2'd1,1'b0,1'b0,1'b0,1'b0,4'b0010,1'b0},
    {2'd2,2'd0,2'd1,1'b0,1'b0,1'b0,1'b0,4'b0000,1'b1},
    {2'd2,2'd0,2'd2,1'b0,1'b1,1'b0,1'b0,4'b0010,1'b1},
    {2'd2,2'd0,2'd1,1'b0,1'b1,1'b0,1'b0,4'b0010,1'b0},
    {2'd2,2'd1,2'd1,1'b0,1'b0,1'b0,1'b0,4'b1010,1'b1},
    {2'd3,2'd0,2'd1,1'b0,1'b0,1'b0,1'b0,4'b0111,1'b1},
    {2'd1,2'd1,2'd0,1'b1,1'b0,1'b0,1'b0,4'b1000,1'b1}
  };

  logic [7:0] frm [0:127];
  int flen;
  int n_checks = 0;
  int n_errors = 0;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic build(input vec_t v);
    int p, l, tot, cl, cpos;
    logic [31:0] s;
    logic [7:0] pr;
    logic [15:0] lw, c;
    p = v.odd ? 11 : 12;
    l = 8 + p;
    tot = 20 + l;
    pr = (v.kind == 2'd0) ? 8'd1 : (v.kind == 2'd1) ? 8'd17 : (v.kind == 2'd2) ? 8'd136 : 8'd6;
    for (int i = 0; i < 128; i++) frm[i] = 8'h00;
    frm[0] = 8'h02; frm[5] = 8'h01; frm[6] = 8'h02; frm[11] = 8'h02;
    frm[12] = 8'h08; frm[13] = 8'h00; frm[14] = 8'h45;
    frm[16] = 8'(tot >> 8); frm[17] = 8'(tot);
    if (v.frag == 2'd1) frm[20] = 8'h20;
    if (v.frag == 2'd2) frm[21] = 8'h10;
    frm[22] = 8'h40; frm[23] = pr;
    frm[26] = 8'hc0; frm[27] = 8'ha8; frm[28] = 8'h00; frm[29] = 8'h01;
    frm[30] = 8'hc0; frm[31] = 8'ha8; frm[32] = 8'h00; frm[33] = 8'h02;
    lw = (v.kind == 2'd2) ? (v.cov ? 16'd12 : 16'd0) : 16'(l);
    if (v.kind == 2'd0) begin
      frm[34] = 8'h08; frm[39] = 8'h01; frm[41] = 8'h07;
      cpos = 36;
    end else begin
      frm[34] = 8'h04; frm[35] = 8'hd2; frm[36] = 8'h16; frm[37] = 8'h2e;
      frm[38] = lw[15:8]; frm[39] = lw[7:0];
      cpos = 40;
    end
    for (int i = 0; i < p; i++) frm[42 + i] = 8'((i * 37 + 5) & 255);
    cl = (v.kind == 2'd2 && v.cov) ? 12 : l;
    s = 32'd0;
    for (int i = 0; i < cl; i++)
      s = s + ((i % 2 == 0) ? {16'h0, frm[34 + i], 8'h00} : {24'h0, frm[34 + i]});
    if (v.kind != 2'd0) s = s + 32'hc0a8 + 32'h1 + 32'hc0a8 + 32'h2 + {24'h0, pr} + {16'h0, lw};
    s = {16'h0, s[15:0]} + {16'h0, s[31:16]};
    s = {16'h0, s[15:0]} + {16'h0, s[31:16]};
    c = ~s[15:0];
    if (v.kind != 2'd0 && c == 16'h0) c = 16'hffff;
    if (v.zero) c = 16'h0;
    frm[cpos] = c[15:8]; frm[cpos + 1] = c[7:0];
    if (v.cor == 2'd1) frm[43] = frm[43] ^ 8'h5a;
    if (v.cor == 2'd2) frm[48] = frm[48] ^ 8'h5a;
    flen = 34 + l;
    if (v.pad) begin
      for (int i = 0; i < 6; i++) frm[flen + i] = 8'h55;
      flen = flen + 6;
    end
  endtask

  task automatic set_cfg(input logic [3:0] c);
    {cfg_frag_pass, cfg_zero_pass, cfg_lite_en, cfg_icmp_chk} = c;
  endtask

  task automatic send(input logic exp, input string tag, input logic late_flip);
    for (int i = 0; i < flen; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = frm[i];
      in_last  = (i == flen - 1);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    if (late_flip) cfg_icmp_chk = ~cfg_icmp_chk;
    chk(verdict_valid == 1'b0, "R1 early strobe", int'(verdict_valid), 0);
    @(negedge clk);
    chk(verdict_valid == 1'b1, "R1 strobe", int'(verdict_valid), 1);
    chk(verdict_pass == exp, tag, int'(verdict_pass), int'(exp));
    @(negedge clk);
    chk(verdict_valid == 1'b0, "R1 single strobe", int'(verdict_valid), 0);
  endtask

  function automatic string tag_of(input vec_t v);
    if (v.kind == 2'd0) return (v.frag != 2'd0) ? "R4 icmp fragment" : "R3 icmp";
    if (v.kind == 2'd1) begin
      if (v.frag != 2'd0) return "R7 udp fragment";
      if (v.zero) return "R6 zero checksum";
      if (v.odd || v.pad) return "R10 bound/odd";
      return "R5 udp";
    end
    if (v.kind == 2'd2) return v.cov ? "R9 coverage" : "R8 udp-lite";
    return "R2 other protocol";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    chk(verdict_valid == 1'b0, "R1 reset valid", int'(verdict_valid), 0);
    chk(verdict_pass == 1'b0, "R1 reset pass", int'(verdict_pass), 0);
    rst = 1'b0;
    @(negedge clk);

    for (int k = 0; k < NVEC; k++) begin
      v = vec_t'(TBL[k]);
      build(v);
      set_cfg(v.cfg);
      send(v.exp, tag_of(v), 1'b0);
    end

    // R2: wrong EtherType, bad UDP checksum, everything enabled
    v = vec_t'(TBL[6]);
    build(v); frm[12] = 8'h86; frm[13] = 8'hdd;
    set_cfg(4'b0111);
    send(1'b1, "R2 ethertype", 1'b0);

    // R2: version 6 in the version nibble
    build(v); frm[14] = 8'h65;
    send(1'b1, "R2 version", 1'b0);

    // R11: frame ends before the UDP checksum field, zero-pass off
    build(v); flen = 40;
    set_cfg(4'b0000);
    send(1'b1, "R11 truncated", 1'b0);

    // R12: bad ICMP, checking off at the final beat, switched on just after
    v = vec_t'(TBL[1]);
    build(v);
    set_cfg(4'b0000);
    send(1'b1, "R12 late config", 1'b1);

    // R12 companion: the same frame with checking on at the final beat
    set_cfg(4'b0001);
    send(1'b0, "R12 config at last beat", 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule